// File: doc/BRIEF.md
# Dual-Mode Processor Counter/Timer

This block is one processor's counter/timer. It runs in one of two modes, chosen by a mode bit that arrives from a shared mode register outside the block.

In counter mode it is a limit-match timer. A 22-bit period count advances on every 500 ns tick strobe. When the count reaches a programmed non-zero limit, it returns to zero, sets a reached flag and asserts an interrupt. Software acknowledges the event by reading the limit.

In user mode the same four word addresses give access to a 63-bit count instead. Software can load its upper and lower words, and can start and stop it through a run bit. The count never interrupts. An upper-word read captures the matching lower word, so a two-read 64-bit access is consistent.

Changes of the mode bit have side effects on the interrupt, the limit and whether the count advances. The register port is word addressed: `addr` 0, 1, 2 and 3 stand for byte offsets 0x0, 0x4, 0x8 and 0xC. A register value of V in bits 30:9 means V periods of 500 ns. Read data is registered and appears one cycle after `rd_en`.

Top module: `proc_ctr_timer`

## Requirements
- R1: After reset the count and the limit are 0, the run bit is 1, the reached flag and `irq` are 0, and the block is in counter mode. In that state addr 1 reads 0x0, addr 3 reads 0x1 and addr 0 reads 0x0.
- R2: In counter mode each `tick` adds 0x200 to the count. Reading addr 1 returns {reached in bit 31, count bits 30:9, zeros in bits 8:0}.
- R3: In counter mode with a non-zero limit L, a tick that would take the count to L sets the count to 0, sets reached and asserts `irq`. With limit 0 the count runs freely: it goes from 0x7FFFFC00 to 0 without setting reached or `irq`.
- R4: In counter mode, the following register accesses apply:
  - Writing addr 0 loads the limit from bits 30:9, clears the count and deasserts `irq`.
  - Writing addr 2 loads the limit and leaves the count unchanged.
  - Reading addr 0 returns the limit and clears reached and `irq`.
  - Writing addr 1 has no effect.
  - Reading addr 2 returns 0.
- R5: In counter mode the count advances on every tick whatever the run bit holds.
- R6: In user mode, reading addr 0 returns {reached in bit 31, count bits 62:32} and captures count bits 31:0. Reading addr 1 returns that captured value, with bits 8:0 zero. A carry out of the lower word reaches the upper word.
- R7: In user mode, writing addr 0 loads count bits 62:32 from data bits 30:0. Writing addr 1 loads count bits 31:9 from data bits 31:9. Either write clears reached, and later ticks count on from the loaded value.
- R8: Writing addr 3 stores data bit 0 as the run bit, and reading addr 3 returns it in bit 0. In user mode a tick advances the count only while the run bit is 1.
- R9: In user mode a tick at count 0x7FFFFFFFFFFFFE00 sets the count to 0 and sets reached. `irq` is never asserted in user mode.
- R10: On a change of the mode bit from 0 to 1, the following take effect:
  - `irq` is deasserted.
  - The limit is forced to its maximum, which reads as 0x7FFFFE00 in counter mode.
  - The count keeps its value.
- R11: On a change of the mode bit from 1 to 0, the count resumes advancing on every tick even when the run bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle strobe per 500 ns period |
| user_mode | input | 1 | Mode bit for this processor: 1 selects user mode, 0 selects counter mode |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Word index of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after `rd_en` |
| irq | output | 1 | Limit-match interrupt |

## Verification
The hardest case to reach from the ports is the free-running wrap in counter mode. It needs a count of 0x7FFFFC00, which takes about four million ticks to reach by counting, and counter mode offers no way to load the count. The stimulus gets there in four steps:
1. Load the lower word in user mode.
2. Switch back to counter mode, which leaves the forced maximum limit in place.
3. Clear the limit through the non-resetting address.
4. Apply one tick, and check that the count wraps to zero with no flag and no interrupt.

The 63-bit roll-over and the carry from the lower word into the upper word are reached in the same way, through direct word loads.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  // Word indices of the register port
  typedef enum logic [1:0] {
    A_LIM   = 2'd0,
    A_CNT   = 2'd1,
    A_LIMNR = 2'd2,
    A_STAT  = 2'd3
  } tmr_addr_e;
endpackage

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int DW  = 32,
  parameter int CW  = 54,
  parameter int LW  = 22,
  parameter int LOW = 23
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          user,
  input  logic          run,
  input  logic          ld_hi,
  input  logic          ld_lo,
  input  logic          cnt_clr,
  input  logic [DW-1:0] wdata,
  input  logic [LW-1:0] lim_p,
  output logic [CW-1:0] cnt,
  output logic          match_evt,
  output logic          top_evt
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic [LW:0]   lo_inc;
  logic [LW-1:0] eff_lim;

  assign lo_inc  = {1'b0, cnt_q[LW-1:0]} + {{LW{1'b0}}, 1'b1};
  assign eff_lim = (lim_p == '0) ? {LW{1'b1}} : lim_p;

  always_comb begin
    cnt_d     = cnt_q;
    match_evt = 1'b0;
    top_evt   = 1'b0;
    if (user) begin
      cnt_en = ld_hi | ld_lo | (tick & run);
      if (ld_hi) cnt_d[CW-1:LOW] = wdata[CW-LOW-1:0];
      if (ld_lo) cnt_d[LOW-1:0]  = wdata[DW-1:DW-LOW];
      if (!ld_hi && !ld_lo && tick && run) begin
        if (&cnt_q) begin
          cnt_d   = '0;
          top_evt = 1'b1;
        end else begin
          cnt_d = cnt_q + {{(CW-1){1'b0}}, 1'b1};
        end
      end
    end else begin
      cnt_en = cnt_clr | tick;
      if (cnt_clr) begin
        cnt_d = '0;
      end else if (tick) begin
        if (lo_inc >= {1'b0, eff_lim}) begin
          cnt_d     = '0;
          match_evt = (lim_p != '0);
        end else begin
          cnt_d = {{(CW-LW){1'b0}}, lo_inc[LW-1:0]};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  // R8
  user_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (user && !run && !ld_hi && !ld_lo) |=> $stable(cnt_q));

  // R5
  ctr_narrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!user && tick && !cnt_clr) |=> (cnt_q[CW-1:LW] == '0));
endmodule

// File: rtl/tmr_flags.sv
module tmr_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic user_in,
  input  logic match_evt,
  input  logic top_evt,
  input  logic clr_rd,
  input  logic clr_ld,
  input  logic cnt_clr,
  output logic mode_q,
  output logic enter_user,
  output logic reached,
  output logic irq
);
  logic reached_q, reached_d;
  logic irq_q, irq_d;

  assign enter_user = user_in & ~mode_q;

  always_comb begin
    reached_d = reached_q;
    if (match_evt || top_evt)  reached_d = 1'b1;
    else if (clr_rd || clr_ld) reached_d = 1'b0;

    irq_d = irq_q;
    if (enter_user)              irq_d = 1'b0;
    else if (match_evt)          irq_d = 1'b1;
    else if (clr_rd || cnt_clr)  irq_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= 1'b0;
      reached_q <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      mode_q    <= user_in;
      reached_q <= reached_d;
      irq_q     <= irq_d;
    end
  end

  assign reached = reached_q;
  assign irq     = irq_q;

  // R9
  no_user_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q |-> !irq_q);

  // R3
  reached_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reached_q) |-> $past(match_evt || top_evt));
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int DW   = 32,
  parameter int FRAC = 9,
  parameter int CW   = 54,
  parameter int LW   = 22,
  parameter int LOW  = 23
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [1:0]    addr,
  input  logic [LW-1:0] lim_wdata,
  input  logic          run_wdata,
  input  logic          mode_q,
  input  logic          enter_user,
  input  logic [CW-1:0] cnt,
  input  logic          reached,
  output logic          run,
  output logic [LW-1:0] lim_p,
  output logic          ld_hi,
  output logic          ld_lo,
  output logic          cnt_clr,
  output logic          clr_rd,
  output logic          clr_ld,
  output logic [DW-1:0] rdata
);
  tmr_addr_e      a;
  logic           wr_lim, wr_cnt, wr_nr, wr_stat, rd_hi;
  logic           run_q;
  logic [LW-1:0]  lim_q, lim_d;
  logic           lim_en;
  logic [LOW-1:0] snap_q;
  logic [DW-1:0]  rdata_q, rdata_d;

  assign a       = tmr_addr_e'(addr);
  assign wr_lim  = wr_en && (a == A_LIM);
  assign wr_cnt  = wr_en && (a == A_CNT);
  assign wr_nr   = wr_en && (a == A_LIMNR);
  assign wr_stat = wr_en && (a == A_STAT);
  assign rd_hi   = rd_en && (a == A_LIM) && mode_q;

  assign ld_hi   = wr_lim & mode_q;
  assign ld_lo   = wr_cnt & mode_q;
  assign clr_ld  = ld_hi | ld_lo;
  assign cnt_clr = wr_lim & ~mode_q;
  assign clr_rd  = rd_en && (a == A_LIM) && !mode_q;

  assign lim_en = enter_user | wr_nr | cnt_clr;
  always_comb begin
    if (enter_user) lim_d = {LW{1'b1}};
    else            lim_d = lim_wdata;
  end

  always_comb begin
    unique case (a)
      A_LIM:   rdata_d = mode_q ? {reached, cnt[CW-1:LOW]}
                                : {1'b0, lim_q, {FRAC{1'b0}}};
      A_CNT:   rdata_d = mode_q ? {snap_q, {FRAC{1'b0}}}
                                : {reached, cnt[LW-1:0], {FRAC{1'b0}}};
      A_LIMNR: rdata_d = '0;
      default: rdata_d = {{(DW-1){1'b0}}, run_q};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b1;
      lim_q   <= '0;
      snap_q  <= '0;
      rdata_q <= '0;
    end else begin
      if (wr_stat) run_q   <= run_wdata;
      if (lim_en)  lim_q   <= lim_d;
      if (rd_hi)   snap_q  <= cnt[LOW-1:0];
      if (rd_en)   rdata_q <= rdata_d;
    end
  end

  assign run   = run_q;
  assign lim_p = lim_q;
  assign rdata = rdata_q;

  // R6
  low_frac_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (a == A_CNT)) |=> (rdata_q[FRAC-1:0] == '0));

  // R4
  nr_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (a == A_LIMNR)) |=> (rdata_q == '0));
endmodule

// File: rtl/proc_ctr_timer.sv
module proc_ctr_timer #(
  parameter int DW   = 32,
  parameter int FRAC = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          user_mode,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq
);
  localparam int LW  = DW - 1 - FRAC;
  localparam int LOW = DW - FRAC;
  localparam int CW  = 2 * DW - 1 - FRAC;

  logic          mode_q, enter_user, reached, run;
  logic          ld_hi, ld_lo, cnt_clr, clr_rd, clr_ld;
  logic          match_evt, top_evt;
  logic [LW-1:0] lim_p;
  logic [CW-1:0] cnt;

  tmr_count #(.DW(DW), .CW(CW), .LW(LW), .LOW(LOW)) u_count (
    .clk(clk), .rst_n(rst_n), .tick(tick), .user(mode_q), .run(run),
    .ld_hi(ld_hi), .ld_lo(ld_lo), .cnt_clr(cnt_clr), .wdata(wdata),
    .lim_p(lim_p), .cnt(cnt), .match_evt(match_evt), .top_evt(top_evt)
  );

  tmr_flags u_flags (
    .clk(clk), .rst_n(rst_n), .user_in(user_mode), .match_evt(match_evt),
    .top_evt(top_evt), .clr_rd(clr_rd), .clr_ld(clr_ld), .cnt_clr(cnt_clr),
    .mode_q(mode_q), .enter_user(enter_user), .reached(reached), .irq(irq)
  );

  tmr_regs #(.DW(DW), .FRAC(FRAC), .CW(CW), .LW(LW), .LOW(LOW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .lim_wdata(wdata[DW-2:FRAC]), .run_wdata(wdata[0]), .mode_q(mode_q),
    .enter_user(enter_user), .cnt(cnt), .reached(reached), .run(run),
    .lim_p(lim_p), .ld_hi(ld_hi), .ld_lo(ld_lo), .cnt_clr(cnt_clr),
    .clr_rd(clr_rd), .clr_ld(clr_ld), .rdata(rdata)
  );
endmodule

// File: tb/sim_proc_ctr_timer.sv
module sim_proc_ctr_timer;
  localparam int CLK_P = 10;
  localparam int WD_CYC = 20000;

  logic        clk, rst_n, tick, user_mode, wr_en, rd_en;
  logic [1:0]  addr;
  logic [31:0] wdata, rdata;
  logic        irq;
  int          checks, errors;

  proc_ctr_timer u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .user_mode(user_mode),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq(irq)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  // op: 0 write, 1 read+check, 2 ticks (d = count), 3 mode (d[0]), 4 irq check
  typedef struct packed {
    logic [2:0]  op;
    logic [1:0]  a;
    logic [31:0] d;
    logic [31:0] e;
    logic [7:0]  r;
  } vec_t;

  localparam int NV = 79;
  localparam vec_t VEC [NV] = '{
    '{3'd1, 2'd1, 32'h0, 32'h0, 8'd1},            // R1 count
    '{3'd1, 2'd3, 32'h0, 32'h1, 8'd1},            // R1 run
    '{3'd1, 2'd0, 32'h0, 32'h0, 8'd1},            // R1 limit
    '{3'd4, 2'd0, 32'h0, 32'h0, 8'd1},            // R1 irq
    '{3'd2, 2'd0, 32'd3, 32'h0, 8'd2},            // R2
    '{3'd1, 2'd1, 32'h0, 32'h600, 8'd2},          // R2
    '{3'd0, 2'd0, 32'h800, 32'h0, 8'd4},          // R4 limit+reset
    '{3'd1, 2'd1, 32'h0, 32'h0, 8'd4},            // R4
    '{3'd2, 2'd0, 32'd3, 32'h0, 8'd3},            // R3
    '{3'd1, 2'd1, 32'h0, 32'h600, 8'd2},          // R2
    '{3'd4, 2'd0, 32'h0, 32'h0, 8'd3},            // R3
    '{3'd2, 2'd0, 32'd1, 32'h0, 8'd3},            // R3 match
    '{3'd4, 2'd0, 32'h0, 32'h1, 8'd3},            // R3
    '{3'd1, 2'd1, 32'h0, 32'h80000000, 8'd3},     // R3
    '{3'd1, 2'd0, 32'h0, 32'h800, 8'd4},          // R4 ack
    '{3'd4, 2'd0, 32'h0, 32'h0, 8'd4},            // R4
    '{3'd1, 2'd1, 32'h0, 32'h0, 8'd4},            // R4
    '{3'd0, 2'd1, 32'h1234, 32'h0, 8'd4},         // R4 ignored
    '{3'd1, 2'd1, 32'h0, 32'h0, 8'd4},            // R4
    '{3'd2, 2'd0, 32'd2, 32'h0, 8'd2},            // R2
    '{3'd0, 2'd2, 32'h10000, 32'h0, 8'd4},        // R4 no reset
    '{3'd1, 2'd1, 32'h0, 32'h400, 8'd4},          // R4
    '{3'd1, 2'd2, 32'h0, 32'h0, 8'd4},            // R4
    '{3'd0, 2'd3, 32'h0, 32'h0, 8'd5},            // R5
    '{3'd2, 2'd0, 32'd1, 32'h0, 8'd5},            // R5
    '{3'd1, 2'd1, 32'h0, 32'h600, 8'd5},          // R5
    '{3'd1, 2'd3, 32'h0, 32'h0, 8'd8},            // R8
    '{3'd3, 2'd0, 32'h1, 32'h0, 8'd10},           // R10
    '{3'd4, 2'd0, 32'h0, 32'h0, 8'd10},           // R10
    '{3'd2, 2'd0, 32'd2, 32'h0, 8'd10},           // R10
    '{3'd1, 2'd0, 32'h0, 32'h0, 8'd6},            // R6
    '{3'd1, 2'd1, 32'h0, 32'h600, 8'd10},         // R10 held
    '{3'd0, 2'd3, 32'h1, 32'h0, 8'd8},            // R8 start
    '{3'd2, 2'd0, 32'd2, 32'h0, 8'd8},            // R8
    '{3'd1, 2'd0, 32'h0, 32'h0, 8'd6},            // R6
    '{3'd1, 2'd1, 32'h0, 32'hA00, 8'd8},          // R8
    '{3'd0, 2'd0, 32'h12345678, 32'h0, 8'd7},     // R7
    '{3'd0, 2'd1, 32'hABCDEF12, 32'h0, 8'd7},     // R7
    '{3'd1, 2'd0, 32'h0, 32'h12345678, 8'd7},     // R7
    '{3'd1, 2'd1, 32'h0, 32'hABCDEE00, 8'd7},     // R7
    '{3'd2, 2'd0, 32'd1, 32'h0, 8'd7},            // R7
    '{3'd1, 2'd0, 32'h0, 32'h12345678, 8'd7},     // R7
    '{3'd1, 2'd1, 32'h0, 32'hABCDF000, 8'd7},     // R7
    '{3'd1, 2'd0, 32'h0, 32'h12345678, 8'd6},     // R6 snapshot
    '{3'd2, 2'd0, 32'd1, 32'h0, 8'd6},            // R6
    '{3'd1, 2'd1, 32'h0, 32'hABCDF000, 8'd6},     // R6 stale half
    '{3'd1, 2'd0, 32'h0, 32'h12345678, 8'd6},     // R6
    '{3'd1, 2'd1, 32'h0, 32'hABCDF200, 8'd6},     // R6
    '{3'd0, 2'd1, 32'hFFFFFE00, 32'h0, 8'd6},     // R6
    '{3'd2, 2'd0, 32'd1, 32'h0, 8'd6},            // R6 carry
    '{3'd1, 2'd0, 32'h0, 32'h12345679, 8'd6},     // R6
    '{3'd1, 2'd1, 32'h0, 32'h0, 8'd6},            // R6
    '{3'd0, 2'd0, 32'hFFFFFFFF, 32'h0, 8'd9},     // R9
    '{3'd0, 2'd1, 32'hFFFFFE00, 32'h0, 8'd9},     // R9
    '{3'd1, 2'd0, 32'h0, 32'h7FFFFFFF, 8'd9},     // R9
    '{3'd2, 2'd0, 32'd1, 32'h0, 8'd9},            // R9 top
    '{3'd4, 2'd0, 32'h0, 32'h0, 8'd9},            // R9
    '{3'd1, 2'd0, 32'h0, 32'h80000000, 8'd9},     // R9
    '{3'd1, 2'd1, 32'h0, 32'h0, 8'd9},            // R9
    '{3'd0, 2'd1, 32'h0, 32'h0, 8'd7},            // R7 clears reached
    '{3'd1, 2'd0, 32'h0, 32'h0, 8'd7},            // R7
    '{3'd0, 2'd1, 32'h7FFFFC00, 32'h0, 8'd3},     // R3 preload
    '{3'd3, 2'd0, 32'h0, 32'h0, 8'd11},           // R11
    '{3'd1, 2'd0, 32'h0, 32'h7FFFFE00, 8'd10},    // R10 forced limit
    '{3'd0, 2'd2, 32'h0, 32'h0, 8'd3},            // R3 free-run
    '{3'd1, 2'd1, 32'h0, 32'h7FFFFC00, 8'd3},     // R3
    '{3'd2, 2'd0, 32'd1, 32'h0, 8'd3},            // R3
    '{3'd1, 2'd1, 32'h0, 32'h0, 8'd3},            // R3 wrap, no flag
    '{3'd4, 2'd0, 32'h0, 32'h0, 8'd3},            // R3
    '{3'd0, 2'd0, 32'h400, 32'h0, 8'd10},         // R10
    '{3'd2, 2'd0, 32'd2, 32'h0, 8'd10},           // R10
    '{3'd4, 2'd0, 32'h0, 32'h1, 8'd10},           // R10
    '{3'd3, 2'd0, 32'h1, 32'h0, 8'd10},           // R10 entry
    '{3'd4, 2'd0, 32'h0, 32'h0, 8'd10},           // R10 irq dropped
    '{3'd3, 2'd0, 32'h0, 32'h0, 8'd11},           // R11
    '{3'd1, 2'd0, 32'h0, 32'h7FFFFE00, 8'd10},    // R10
    '{3'd0, 2'd3, 32'h0, 32'h0, 8'd11},           // R11 run=0
    '{3'd2, 2'd0, 32'd2, 32'h0, 8'd11},           // R11
    '{3'd1, 2'd1, 32'h0, 32'h400, 8'd11}          // R11 still counts
  };

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input int r);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d act %h exp %h", r, act, exp);
    end
  endtask

  task automatic do_wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_rd(input logic [1:0] a, input logic [31:0] e, input int r);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    chk(rdata, e, r);
  endtask

  task automatic do_tick(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
    end
    tick = 1'b0;
  endtask

  initial begin
    repeat (WD_CYC) @(posedge clk);
    errors++;
    $display("FAIL watchdog act timeout exp completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    checks = 0; errors = 0;
    rst_n = 1'b0; tick = 1'b0; user_mode = 1'b0;
    wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      case (VEC[k].op)
        3'd0: do_wr(VEC[k].a, VEC[k].d);
        3'd1: do_rd(VEC[k].a, VEC[k].e, int'(VEC[k].r));
        3'd2: do_tick(int'(VEC[k].d));
        3'd3: begin user_mode = VEC[k].d[0]; @(negedge clk); end
        default: chk({31'b0, irq}, VEC[k].e, int'(VEC[k].r));
      endcase
    end

    // R3 one-period limit, then R1 reset while the interrupt is pending
    do_wr(2'd0, 32'h200);
    do_tick(1);
    chk({31'b0, irq}, 32'h1, 3);
    rst_n = 1'b0;
    #1;
    chk({31'b0, irq}, 32'h0, 1);   // R1 asynchronous clear
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    do_rd(2'd1, 32'h0, 1);         // R1
    do_rd(2'd3, 32'h1, 1);         // R1
    do_rd(2'd0, 32'h0, 1);         // R1

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule